// File: doc/BRIEF.md
# Four-Way Tree Pseudo-LRU Replacement Selector

This block tracks recency for a single four-way cache set with three status bits arranged as a binary tree. A root bit records which half of the set (ways 0/1 or ways 2/3) was touched more recently. Each of the two pair bits records which way inside its own pair was touched more recently. A single strobe with a 2-bit way index marks a touch. Hit references and line fills on a miss both use it.

The victim way is decoded combinationally from the registered tree bits. The decode starts at the root, steps into the less recently used half, and then picks the less recently used way of that pair. Each touch rewrites only the two bits on its own path. A cache controller instantiates one selector per set. It reads the victim when a miss needs a slot and strobes the selector once the fill lands.

Top module: `plru4_tree`

## Requirements
- R1: A synchronous active-high reset clears all three tree bits, so the victim output reads way 3 (2'b11) in the cycle after reset.
- R2: A touch of way 0 or way 1 writes the root bit to 0 and writes the lower pair bit to the low bit of the way index (way 0 → 0, way 1 → 1).
- R3: A touch of way 2 or way 3 writes the root bit to 1 and writes the upper pair bit to the low bit of the way index (way 2 → 0, way 3 → 1).
- R4: The victim decodes from the tree bits as follows. Root 1 with lower pair bit 0 gives way 1, and root 1 with lower pair bit 1 gives way 0. Root 0 with upper pair bit 0 gives way 3, and root 0 with upper pair bit 1 gives way 2.
- R5: A touch leaves the pair bit of the pair it does not address unchanged.
- R6: While the strobe is low, no tree bit changes and the victim holds, whatever the way index input carries.
- R7: In the cycle after a touch, the victim differs from the way just touched.
- R8: A touch takes effect at the next rising clock edge, and the victim follows the new bits in that same cycle with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Touch strobe, used for a hit or a completed fill |
| ref_way | input | 2 | Way index being touched |
| victim_way | output | 2 | Way to replace next |

## Verification
The hardest situation to create from the ports is one where the pair bit that a touch must leave alone holds a non-default value. That bit can only be observed through the victim once the root points at its pair. To reach it, the bench resets and then drives every ordered triple of touches. This reaches all eight tree states through every path and checks each victim against an arithmetic model of the three bits. A directed sequence then sets the upper pair bit, touches the lower pair, and confirms that the victim becomes way 2.

// File: rtl/plru_pkg.sv
package plru_pkg;
  parameter int PLRU_WAYS = 4;
  localparam int PLRU_WAY_W = $clog2(PLRU_WAYS);
  localparam int PLRU_PAIRS = PLRU_WAYS / 2;
endpackage

// File: rtl/plru_node.sv
// One tree status bit: loads the direction of the touched way when the
// touch passes through this node, otherwise holds.
module plru_node (
  input  logic clk,
  input  logic rst,
  input  logic touch,
  input  logic dir,
  output logic bit_q
);
  always_ff @(posedge clk) begin
    if (rst)        bit_q <= 1'b0;
    else if (touch) bit_q <= dir;
  end
endmodule

// File: rtl/plru_victim_sel.sv
// Walk the tree toward the less recent side at every level.
module plru_victim_sel
  import plru_pkg::*;
(
  input  logic                  root_q,
  input  logic [PLRU_PAIRS-1:0] pair_q,
  output logic [PLRU_WAY_W-1:0] victim
);
  logic half_sel;
  logic in_pair;
  always_comb begin
    half_sel = ~root_q;             // root 1: upper half recent -> go low
    in_pair  = ~pair_q[half_sel];   // pick the older way inside the pair
    victim   = {half_sel, in_pair};
  end
endmodule

// File: rtl/plru4_tree.sv
module plru4_tree
  import plru_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ref_valid,
  input  logic [PLRU_WAY_W-1:0] ref_way,
  output logic [PLRU_WAY_W-1:0] victim_way
);
  logic                  root_q;
  logic [PLRU_PAIRS-1:0] pair_q;

  // Root: records which half was touched last (R2, R3)
  plru_node u_root (
    .clk(clk), .rst(rst),
    .touch(ref_valid),
    .dir(ref_way[PLRU_WAY_W-1]),
    .bit_q(root_q)
  );

  // Pair nodes: only the node on the touched path is written (R5)
  for (genvar p = 0; p < PLRU_PAIRS; p++) begin : g_pair
    plru_node u_pair (
      .clk(clk), .rst(rst),
      .touch(ref_valid && (ref_way[PLRU_WAY_W-1] == 1'(p))),
      .dir(ref_way[0]),
      .bit_q(pair_q[p])
    );
  end

  plru_victim_sel u_sel (
    .root_q(root_q),
    .pair_q(pair_q),
    .victim(victim_way)
  );

  // R1: reset leaves way 3 as victim
  a_r1_reset_victim: assert property (@(posedge clk)
    rst |=> victim_way == 2'd3);
  // R2: touching the lower half sends the victim to the upper half
  a_r2_low_touch: assert property (@(posedge clk) disable iff (rst)
    ref_valid && !ref_way[1] |=> victim_way[1] && pair_q[0] == $past(ref_way[0]));
  // R3: touching the upper half sends the victim to the lower half
  a_r3_high_touch: assert property (@(posedge clk) disable iff (rst)
    ref_valid && ref_way[1] |=> !victim_way[1] && pair_q[1] == $past(ref_way[0]));
  // R5: the other pair keeps its bit
  a_r5_other_pair_lo: assert property (@(posedge clk) disable iff (rst)
    ref_valid && ref_way[1] |=> $stable(pair_q[0]));
  a_r5_other_pair_hi: assert property (@(posedge clk) disable iff (rst)
    ref_valid && !ref_way[1] |=> $stable(pair_q[1]));
  // R6: idle cycles hold the victim
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !ref_valid |=> $stable(victim_way));
  // R7: never evict what was just touched
  a_r7_not_just_touched: assert property (@(posedge clk) disable iff (rst)
    ref_valid |=> victim_way != $past(ref_way));
endmodule

// File: tb/tb_plru4_tree.sv
module tb_plru4_tree;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_valid = 1'b0;
  logic [1:0] ref_way = 2'd0;
  logic [1:0] victim_way;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // golden tree bits
  bit m_root, m_lo, m_hi;

  always #2.5 clk = ~clk;

  plru4_tree dut (
    .clk(clk), .rst(rst), .ref_valid(ref_valid),
    .ref_way(ref_way), .victim_way(victim_way)
  );

  function automatic logic [1:0] model_victim();
    if (m_root) return m_lo ? 2'd0 : 2'd1;
    else        return m_hi ? 2'd2 : 2'd3;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: victim=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; ref_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    m_root = 0; m_lo = 0; m_hi = 0;
    check("R1", victim_way, 2'd3);
  endtask

  task automatic touch(logic [1:0] w);
    @(negedge clk); ref_valid = 1'b1; ref_way = w;
    @(negedge clk); ref_valid = 1'b0;
    m_root = w[1];
    if (w[1]) m_hi = w[0]; else m_lo = w[0];
    check("R4/R8 model", victim_way, model_victim());
    checks++;
    if (victim_way == w) begin
      errors++;
      $display("FAIL R7: victim=%0d expected!=%0d", victim_way, w);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    do_reset();

    // R2: touch way 0 -> root 0, lo 0 -> victim 3 (upper pair bit 0)
    touch(2'd0); check("R2", victim_way, 2'd3);
    // R3: touch way 2 -> root 1, lo still 0 -> victim 1
    touch(2'd2); check("R3", victim_way, 2'd1);
    // R2: touch way 1 -> lo 1, root 0, hi 0 -> victim 3
    touch(2'd1); check("R2", victim_way, 2'd3);
    // R4: touch way 3 -> hi 1, root 1, lo 1 -> victim 0
    touch(2'd3); check("R4", victim_way, 2'd0);

    // R5: set hi=1 via way 3, then touch way 0: root 0, hi must stay 1 -> victim 2
    do_reset();
    touch(2'd3);
    touch(2'd0); check("R5", victim_way, 2'd2);
    // R5: lo=1 via way 1, then touch way 2: root 1, lo stays 1 -> victim 0
    touch(2'd1);
    touch(2'd2); check("R5", victim_way, 2'd0);

    // R6: index toggles with strobe low, victim holds
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ref_way = 2'(i);
      check("R6", victim_way, 2'd0);
    end

    // Exhaustive ordered triples from reset (R4, R7, R8)
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          do_reset();
          touch(2'(a)); touch(2'(b)); touch(2'(c));
        end

    // Random sequence against model
    do_reset();
    for (int i = 0; i < 300; i++) touch(2'($urandom_range(3)));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: victim=%0d expected=done", victim_way);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule